// File: doc/BRIEF.md
# Collision and Carrier-Sense Reporter with SQE Heartbeat

This block drives the collision and carrier-sense outputs of a 10 Mb/s media-independent interface. Its inputs are clean digital levels: transmit enable, receive activity, a collision indication from the line logic, a duplex selector and a heartbeat-disable bit. The collision output copies the collision indication. After each transmitted frame it also carries a short signal-quality-error (SQE) test pulse, which tells the MAC that the collision path works.

Carrier sense reflects receive activity in both duplex modes. In half duplex it also reflects local transmission. The SQE pulse appears after a programmable gap once transmit enable drops, and it lasts a programmable number of cycles. One cycle is one bit time at the nominal 10 MHz clock. The pulse is never produced in full duplex or while the heartbeat is disabled. A new transmission discards an SQE that is still pending.

Top module: `col_crs_reporter`

## Requirements
- R1: `col` is 1 in every cycle after a clock edge that samples `coll_det` high, so it stays high for the whole collision, with one register of latency.
- R2: A collision seen while `rx_act` is high is reported with the same one-cycle latency as any other collision, whatever the state of `tx_en`.
- R3: Call edge E the first clock edge that samples `tx_en` low after it was high, with `full_dup`=0 and `hb_dis`=0. Then `col` rises after edge E+SQE_GAP+1.
- R4: The SQE pulse on `col` lasts exactly SQE_LEN cycles, ending after edge E+SQE_GAP+SQE_LEN+1.
- R5: No SQE is started when `full_dup` or `hb_dis` is 1 at edge E. A pending or running SQE is dropped at the first edge that samples either of them high, and `col` then shows only `coll_det`.
- R6: A pending or running SQE is dropped at the first edge that samples `tx_en` high again.
- R7: With `full_dup`=0, `crs` after each edge equals `rx_act | tx_en` as sampled at that edge.
- R8: With `full_dup`=1, `crs` after each edge equals `rx_act` as sampled at that edge, and `tx_en` has no effect on it.
- R9: An edge that samples `rst_n` low clears `col`, `crs` and any pending SQE. No SQE follows a reset, whatever `tx_en` did before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock (10 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx_act | input | 1 | Receive activity (valid data present) |
| coll_det | input | 1 | Collision indication from the line logic |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_dis | input | 1 | 1 = heartbeat (SQE test) disabled |
| col | output | 1 | Collision output, including the SQE pulse |
| crs | output | 1 | Carrier sense output |

## Verification
The bench checks the position of the SQE pulse edge by edge. An off-by-one in the gap counter or the length counter shifts or stretches the pulse by a cycle, and the bench flags that cycle.

Directed cases target three faults:
- a retransmit inside the gap and inside the pulse, where a design without cancellation would pulse during the new frame;
- raising `hb_dis` or `full_dup` mid-pending, where a design that checks only at launch would still pulse;
- a full-duplex frame, where carrier sense wrongly tracking `tx_en` would show up.

A collision during reception, and a reset taken while transmitting, catch a latched or delayed `col` and a stale transmit history.

// File: rtl/col_crs_pkg.sv
package col_crs_pkg;
   typedef enum logic [1:0] {
      SQE_IDLE  = 2'd0,
      SQE_GAP   = 2'd1,
      SQE_PULSE = 2'd2
   } sqe_state_t;
endpackage

// File: rtl/col_crs_sqe.sv
module col_crs_sqe
   import col_crs_pkg::*;
#(
   parameter int GAP_CYC = 10,
   parameter int LEN_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic full_dup,
   input  logic hb_dis,
   output logic sqe_out
);
   localparam int MAXC = (GAP_CYC > LEN_CYC) ? GAP_CYC : LEN_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
   localparam logic [CW-1:0] LEN_LAST = CW'(LEN_CYC - 1);

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
      if (LEN_CYC < 1) begin : g_bad_len
         $error("LEN_CYC must be at least 1");
      end
   endgenerate

   sqe_state_t    state;
   logic [CW-1:0] cnt;
   logic          tx_d;
   logic          inhibit;
   logic          launch;

   assign inhibit = tx_en | full_dup | hb_dis;
   assign launch  = tx_d & ~tx_en & ~full_dup & ~hb_dis;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQE_IDLE;
         cnt   <= '0;
         tx_d  <= 1'b0;
      end else begin
         tx_d <= tx_en;
         unique case (state)
            SQE_IDLE: begin
               if (launch) begin
                  state <= SQE_GAP;
                  cnt   <= '0;
               end
            end
            SQE_GAP: begin
               if (inhibit) begin
                  state <= SQE_IDLE;
               end else if (cnt == GAP_LAST) begin
                  state <= SQE_PULSE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQE_PULSE: begin
               if (inhibit || cnt == LEN_LAST) begin
                  state <= SQE_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SQE_IDLE;
         endcase
      end
   end

   assign sqe_out = (state == SQE_PULSE) & ~inhibit;

   // R6: a new transmission drops anything pending
   a_r6_retx_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SQE_IDLE && tx_en) |=> state == SQE_IDLE);
   // R4: pulse counter never runs past its length
   a_r4_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQE_PULSE) |-> (cnt <= LEN_LAST));
   // R3: pulse is only ever entered from the gap
   a_r3_pulse_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == SQE_PULSE) |-> $past(state == SQE_GAP));
   // R5: heartbeat disable empties the machine
   a_r5_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_dis || full_dup) |=> state == SQE_IDLE);
endmodule

// File: rtl/col_crs_reporter.sv
module col_crs_reporter #(
   parameter int SQE_GAP = 10,
   parameter int SQE_LEN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic rx_act,
   input  logic coll_det,
   input  logic full_dup,
   input  logic hb_dis,
   output logic col,
   output logic crs
);
   logic sqe;

   col_crs_sqe #(
      .GAP_CYC(SQE_GAP),
      .LEN_CYC(SQE_LEN)
   ) i_sqe (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .full_dup(full_dup),
      .hb_dis  (hb_dis),
      .sqe_out (sqe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= 1'b0;
         crs <= 1'b0;
      end else begin
         col <= coll_det | sqe;
         crs <= rx_act | (tx_en & ~full_dup);
      end
   end

   // R1: collision is reported while it lasts
   a_r1_col_tracks_coll: assert property (@(posedge clk) disable iff (!rst_n)
      coll_det |=> col);
   // R7: half duplex carrier includes transmit
   a_r7_crs_half_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !full_dup) |=> crs);
   // R8: full duplex carrier ignores transmit
   a_r8_crs_full_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
      (full_dup && !rx_act) |=> !crs);
endmodule

// File: tb/test_col_crs_reporter.sv
module test_col_crs_reporter;
   localparam int D = 10;
   localparam int L = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, rx_act = 1'b0, coll_det = 1'b0, full_dup = 1'b0, hb_dis = 1'b0;
   logic col, crs;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model of the SQE timeline
   bit m_txp = 1'b0;
   bit pend  = 1'b0;
   int s     = 0;

   always #2.5 clk = ~clk;

   col_crs_reporter #(.SQE_GAP(D), .SQE_LEN(L)) i_col_crs_reporter (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_act(rx_act),
      .coll_det(coll_det), .full_dup(full_dup), .hb_dis(hb_dis),
      .col(col), .crs(crs)
   );

   function automatic bit exp_sqe();
      return pend && (s >= D + 1) && (s <= D + L);
   endfunction

   function automatic bit exp_crs(bit tx, bit rx, bit fd);
      return rx | (tx & ~fd);
   endfunction

   task automatic chk(string tag, logic got, bit exp, string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, model at posedge, compare just after
   task automatic step(bit rst, bit tx, bit rx, bit cd, bit fd, bit hd, string tag);
      bit ec, er;
      string tc, tr;
      @(negedge clk);
      rst_n = ~rst; tx_en = tx; rx_act = rx; coll_det = cd; full_dup = fd; hb_dis = hd;
      @(posedge clk);
      if (rst) begin
         pend = 0; m_txp = 0; s = 0;
         ec = 0; er = 0;
      end else begin
         if (m_txp && !tx && !fd && !hd) begin
            pend = 1; s = 0;
         end else if (pend) begin
            if (tx || fd || hd) pend = 0;
            else begin
               s++;
               if (s > D + L) pend = 0;
            end
         end
         m_txp = tx;
         ec = cd | exp_sqe();
         er = exp_crs(tx, rx, fd);
      end
      #1;
      if (tag != "") begin
         tc = tag; tr = tag;
      end else begin
         tc = cd ? (rx ? "R2" : "R1") : (exp_sqe() ? "R4" : "R3");
         tr = fd ? "R8" : "R7";
      end
      chk(tc, col, ec, "col");
      chk(tr, crs, er, "crs");
   endtask

   task automatic idle(int n, bit fd, bit hd, string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, fd, hd, tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit tx, rx, cd, fd, hd;
      void'($urandom(32'h5EED_0C01));
      // R9: reset state, including reset taken mid-transmit
      step(1, 1, 1, 1, 0, 0, "R9");
      step(1, 1, 1, 1, 0, 0, "R9");
      step(0, 0, 0, 0, 0, 0, "R9");   // no SQE from pre-reset tx
      idle(D + L + 3, 0, 0, "R9");

      // R3/R4: half duplex packet with heartbeat
      for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, 0, "R7");
      idle(D + 1, 0, 0, "R3");
      idle(L, 0, 0, "R4");
      idle(3, 0, 0, "R4");

      // R5: full duplex and heartbeat disabled packets
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 0, "R8");
      idle(D + L + 3, 1, 0, "R5");
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 1, "R7");
      idle(D + L + 3, 0, 1, "R5");

      // R5: disable raised mid-gap and mid-pulse
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R7");
      idle(4, 0, 0, "R3");
      idle(D + L, 0, 1, "R5");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R7");
      idle(D + 3, 0, 0, "R4");
      idle(L, 1, 0, "R5");

      // R6: retransmit inside gap and inside pulse
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R7");
      idle(5, 0, 0, "R3");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R6");
      idle(D + 4, 0, 0, "R4");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R6");
      idle(D + L + 3, 0, 0, "R6");

      // R2: collision while receiving, also while transmitting
      for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0, 0, "R2");
      for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 0, 0, "R2");
      step(0, 0, 1, 0, 0, 0, "");
      // R8: full duplex, tx with no rx
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 0, "R8");
      idle(D + L + 3, 0, 0, "");

      // random traffic
      tx = 0; rx = 0; cd = 0; fd = 0; hd = 0;
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 15) == 0) tx = ~tx;
         if ($urandom_range(0, 11) == 0) rx = ~rx;
         cd = ($urandom_range(0, 40) == 0) ? ~cd : cd;
         if ($urandom_range(0, 300) == 0) fd = ~fd;
         if ($urandom_range(0, 300) == 0) hd = ~hd;
         step(($urandom_range(0, 2000) == 0), tx, rx, cd, fd, hd, "");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule